// File: doc/BRIEF.md
# Busy-Gated Fixed-Priority Bus Arbiter

This block decides which of three masters owns a shared bus. Each master raises its own request line. The arbiter answers with a registered grant vector that has at most one bit set. A bus-busy input comes from the bus side and stays high while the granted transaction is still running.

While busy is high, the grant register is frozen. The current owner keeps the bus even if a master with a higher priority starts requesting, and even if the owner lowers its own request during the transfer. While busy is low, the arbiter makes a fresh choice on every clock edge. It gives the bus to the requesting master with the lowest index, or it grants nobody when no master is requesting.

A master that sees its grant should raise busy for the length of its transfer. When the transfer ends, busy falls and the next choice is made at the following edge.

Top module: `arb_fixed_prio`

## Requirements
- R1: There are three request inputs and three grant outputs, one pair per master. Bit i of each vector belongs to master i. The grant vector is never anything other than all-zero or one-hot.
- R2: When rst is high at a rising clock edge, gnt is all-zero after that edge, whatever the values of req and bus_busy.
- R3: At an edge where rst is low and bus_busy is low, gnt becomes the lowest-index set bit of req. Master 0 beats master 1, and master 1 beats master 2.
- R4: At an edge where rst and bus_busy are low and req is all-zero, gnt becomes all-zero.
- R5: At an edge where rst is low and bus_busy is high, gnt keeps its previous value whatever req does. A higher-priority request never preempts the current owner.
- R6: When busy falls and the current owner's request is low, that owner loses its grant at the first idle edge. The same edge gives the bus to the best other requester.
- R7: If the owner lowers its request while busy is still high, it keeps its grant until the first edge that sees busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 3 | Request lines, bit i from master i |
| bus_busy | input | 1 | High while a granted transfer is in progress |
| gnt | output | 3 | Registered grant, one-hot or all-zero |

## Verification
Two functions can meet in the same cycle. One is the priority choice, which reacts to a fresh higher-priority request. The other is the busy hold, which freezes the register. The bench provokes this by raising master 0's request in the same cycle that master 2 holds the bus with busy high. It does the same during the last busy cycle before busy falls. The hold must win while busy is sampled high, and the priority choice must take over at the first idle edge. Random request and busy patterns then repeat such collisions many times. Each result is compared against a cycle model that keeps the two rules apart.

// File: rtl/arb_pkg.sv
package arb_pkg;
    // Number of masters sharing the bus
    localparam int unsigned NUM_REQ = 3;

    typedef logic [NUM_REQ-1:0] vec_t;

    // Registered state of the arbiter
    typedef struct packed {
        vec_t gnt;
    } arb_state_t;

    localparam arb_state_t ARB_RESET = '{gnt: '0};
endpackage

// File: rtl/arb_prio_pick.sv
// Lowest-index-wins selector: returns the first set bit of req.
module arb_prio_pick #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick
);
    // seen[i] is high when any lower-index request is set
    logic [N-1:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign pick[i] = req[i] & ~seen[i];
        if (i < N - 1) begin : g_chain
            assign seen[i+1] = seen[i] | req[i];
        end
    end
endmodule

// File: rtl/arb_next_ctrl.sv
// Computes the next arbiter state from the current state and inputs.
module arb_next_ctrl
    import arb_pkg::*;
(
    input  arb_state_t state_q,
    input  vec_t       pick,
    input  logic       bus_busy,
    output arb_state_t state_d
);
    always_comb begin
        state_d = state_q;
        if (!bus_busy) begin
            // Idle bus: fresh decision; owner without request is released
            state_d.gnt = pick;
        end
    end
endmodule

// File: rtl/arb_fixed_prio.sv
module arb_fixed_prio
    import arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] req,
    input  logic               bus_busy,
    output logic [NUM_REQ-1:0] gnt
);
    arb_state_t state_d;
    arb_state_t state_q;
    vec_t       pick;

    arb_prio_pick #(.N(NUM_REQ)) u_pick (
        .req  (req),
        .pick (pick)
    );

    arb_next_ctrl u_ctrl (
        .state_q  (state_q),
        .pick     (pick),
        .bus_busy (bus_busy),
        .state_d  (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign gnt = state_q.gnt;
endmodule

// File: rtl/arb_chk.sv
module arb_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] req,
    input logic       bus_busy,
    input logic [2:0] gnt
);
    // R1
    onehot_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (gnt == 3'b000));

    // R3
    prio0_win_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_busy && req[0]) |=> (gnt == 3'b001));

    // R3
    prio1_win_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_busy && req[1] && !req[0]) |=> (gnt == 3'b010));

    // R4
    idle_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_busy && req == 3'b000) |=> (gnt == 3'b000));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bus_busy |=> $stable(gnt));
endmodule

bind arb_fixed_prio arb_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .bus_busy (bus_busy),
    .gnt      (gnt)
);

// File: tb/sim_arb_fixed_prio.sv
`timescale 1ns/1ps
module sim_arb_fixed_prio;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] req = 3'b000;
    logic       bus_busy = 1'b0;
    logic [2:0] gnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0] exp_q[$];
    string      tag_q[$];
    logic [2:0] model = 3'b000;

    always #5 clk = ~clk;

    arb_fixed_prio u0 (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .bus_busy (bus_busy),
        .gnt      (gnt)
    );

    function automatic logic [2:0] first_set(input logic [2:0] r);
        if (r[0]) return 3'b001;
        if (r[1]) return 3'b010;
        if (r[2]) return 3'b100;
        return 3'b000;
    endfunction

    // Driver: applies inputs for one edge and pushes the expected grant
    task automatic step(input logic r, input logic [2:0] rq, input logic b,
                        input string tag);
        @(negedge clk);
        rst      = r;
        req      = rq;
        bus_busy = b;
        if (r)      model = 3'b000;
        else if (!b) model = first_set(rq);
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (gnt !== e) begin
                    errors++;
                    $display("FAIL %s: gnt=%b expected=%b", t, gnt, e);
                end
                checks++;
                if (!$onehot0(gnt)) begin
                    errors++;
                    $display("FAIL R1: gnt=%b expected one-hot or zero", gnt);
                end
            end
        end
    end

    initial begin
        // R2: reset with requests and busy present
        step(1'b1, 3'b111, 1'b1, "R2");
        step(1'b1, 3'b101, 1'b0, "R2");
        // R4: idle, nobody asks
        step(1'b0, 3'b000, 1'b0, "R4");
        // R3: priority patterns
        step(1'b0, 3'b100, 1'b0, "R3");
        step(1'b0, 3'b110, 1'b0, "R3");
        step(1'b0, 3'b111, 1'b0, "R3");
        step(1'b0, 3'b010, 1'b0, "R3");
        // R5: master 2 owns the bus, master 0 arrives while busy
        step(1'b0, 3'b100, 1'b0, "R3");
        step(1'b0, 3'b101, 1'b1, "R5");
        step(1'b0, 3'b111, 1'b1, "R5");
        // R7: owner drops its request while still busy
        step(1'b0, 3'b011, 1'b1, "R7");
        step(1'b0, 3'b001, 1'b1, "R7");
        // R6: busy falls, owner idle -> master 0 wins at once
        step(1'b0, 3'b001, 1'b0, "R6");
        // R6: owner 0 released with nobody else -> empty
        step(1'b0, 3'b000, 1'b1, "R5");
        step(1'b0, 3'b000, 1'b0, "R6");
        // R6: owner 1 released, master 2 takes over
        step(1'b0, 3'b010, 1'b0, "R3");
        step(1'b0, 3'b110, 1'b1, "R5");
        step(1'b0, 3'b100, 1'b0, "R6");
        // R2: reset in mid-transfer
        step(1'b1, 3'b100, 1'b1, "R2");
        // Random collisions of priority and busy hold
        for (int i = 0; i < 400; i++) begin
            logic [2:0] rq;
            logic b;
            logic r;
            rq = 3'($urandom_range(0, 7));
            b  = ($urandom_range(0, 2) != 0);
            r  = ($urandom_range(0, 60) == 0);
            step(r, rq, b, r ? "R2" : (b ? "R5" : (rq == 3'b000 ? "R4" : "R3")));
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule